// File: doc/BRIEF.md
# Funnel Shift and Rotate Unit

This block performs every shift and rotate of a 32-bit integer datapath with one shared selection network. For each operation it builds a 64-bit funnel word from two 32-bit halves. Depending on the operation, each half holds the operand, zeros, copies of the operand's sign bit, or copies of a carry bit. It then takes a 32-bit window of that word as if the word had been moved left and its upper half kept. Right-direction operations by `n` are turned into left moves by `32 - n`, so the select logic has only one direction.

A producer presents an operand, a 5-bit amount, a carry bit and a 3-bit operation code, together with a valid strobe. The result is captured on the next rising clock edge. It appears one cycle later along with a delayed copy of the strobe. Condition flags and other arithmetic are left to neighbouring logic.

Top module: `funnel_shifter`

## Requirements
- R1: Operation code 000 (logical left shift) returns the operand moved left by `amount`, with zeros entering at bit 0.
- R2: Operation code 001 (logical right shift) returns the operand moved right by `amount`, with zeros entering at bit 31.
- R3: Operation code 010 (arithmetic right shift) returns the operand moved right by `amount`, with copies of operand bit 31 entering at the top.
- R4: Operation code 011 rotates left and code 100 rotates right by `amount`. Bits leaving one end re-enter at the other, and the number of set bits is preserved.
- R5: Operation code 101 moves the operand left by `amount` and fills the vacated low `amount` bits with copies of `carry_in`.
- R6: Operation code 110 moves the operand right by `amount` and fills the vacated high `amount` bits with copies of `carry_in`.
- R7: Any right-direction operation (codes 001, 010, 100, 110) with `amount` = 0 returns the operand unchanged, whatever `carry_in` is.
- R8: Operation code 111 returns the operand unchanged for every `amount` and `carry_in`.
- R9: `result` reflects the inputs sampled at the previous rising edge, and `out_valid` equals `in_valid` from that same edge.
- R10: While `rst` is high at a rising edge, `result` is cleared to zero and `out_valid` to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking the inputs as meaningful |
| operand | input | 32 | Source value |
| amount | input | 5 | Move count, 0 to 31 |
| carry_in | input | 1 | Fill bit for the through-carry rotates |
| op | input | 3 | Operation code (see R1 to R8) |
| out_valid | output | 1 | Strobe delayed by one cycle |
| result | output | 32 | Registered result |

## Verification
Each operation is driven with several operands. These include a lone set bit, an alternating pattern, a negative value and an all-ones value, so that fill bits can be told apart from bits that moved. Every amount from 0 to 31 is swept on a fixed operand. This separates the left-move path from the `32 - n` path and exposes an off-by-one in the window index. The through-carry rotates are run with both carry values, so a fill that is stuck at zero or taken from the wrong half shows up. Amount 0 on right operations, and the pass-through code, cover the edge position of the window.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic [2:0] {
        OP_SLL  = 3'b000,
        OP_SRL  = 3'b001,
        OP_SRA  = 3'b010,
        OP_ROL  = 3'b011,
        OP_ROR  = 3'b100,
        OP_RCL  = 3'b101,
        OP_RCR  = 3'b110,
        OP_PASS = 3'b111
    } shift_op_e;

    // true for operations that move toward bit 0
    function automatic logic op_is_right(input shift_op_e o);
        return (o == OP_SRL) || (o == OP_SRA) || (o == OP_ROR) || (o == OP_RCR);
    endfunction

endpackage

// File: rtl/fsh_fill.sv
module fsh_fill
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  shift_op_e          op_i,
    input  logic [WIDTH-1:0]   src_i,
    input  logic               carry_i,
    output logic [2*WIDTH-1:0] word_o,
    output logic               right_o
);
    logic [WIDTH-1:0] hi_d;
    logic [WIDTH-1:0] lo_d;
    logic [WIDTH-1:0] sign_fill;
    logic [WIDTH-1:0] carry_fill;

    assign sign_fill  = {WIDTH{src_i[WIDTH-1]}};
    assign carry_fill = {WIDTH{carry_i}};

    always_comb begin
        hi_d = '0;
        lo_d = '0;
        unique case (op_i)
            OP_SLL:  begin hi_d = src_i;      lo_d = '0;         end
            OP_SRL:  begin hi_d = '0;         lo_d = src_i;      end
            OP_SRA:  begin hi_d = sign_fill;  lo_d = src_i;      end
            OP_ROL,
            OP_ROR:  begin hi_d = src_i;      lo_d = src_i;      end
            OP_RCL:  begin hi_d = src_i;      lo_d = carry_fill; end
            OP_RCR:  begin hi_d = carry_fill; lo_d = src_i;      end
            default: begin hi_d = src_i;      lo_d = '0;         end
        endcase
    end

    assign word_o  = {hi_d, lo_d};
    assign right_o = op_is_right(op_i);

endmodule

// File: rtl/fsh_amount.sv
module fsh_amount #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH),
    localparam int MOV_W = AMT_W + 1
) (
    input  logic [AMT_W-1:0] amt_i,
    input  logic             right_i,
    input  logic             pass_i,
    output logic [MOV_W-1:0] move_o
);
    localparam logic [MOV_W-1:0] FULL = MOV_W'(WIDTH);

    logic [MOV_W-1:0] amt_ext;

    assign amt_ext = {1'b0, amt_i};

    // a right move by n becomes a left move by WIDTH-n; n=0 gives WIDTH
    always_comb begin
        if (pass_i)
            move_o = '0;
        else if (right_i)
            move_o = FULL - amt_ext;
        else
            move_o = amt_ext;
    end

endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
    parameter int WIDTH = 32,
    localparam int MOV_W = $clog2(WIDTH) + 1
) (
    input  logic [2*WIDTH-1:0] word_i,
    input  logic [MOV_W-1:0]   move_i,
    output logic [WIDTH-1:0]   win_o
);
    // upper half of (word << move) is the slice starting at WIDTH-move
    always_comb begin
        win_o = '0;
        for (int p = 0; p <= WIDTH; p++) begin
            if (move_i == MOV_W'(p))
                win_o = word_i[(WIDTH - p) +: WIDTH];
        end
    end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH),
    localparam int MOV_W = AMT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry_in,
    input  logic [2:0]       op,
    output logic             out_valid,
    output logic [WIDTH-1:0] result
);
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } stage_t;

    shift_op_e          op_e;
    logic [2*WIDTH-1:0] funnel_word;
    logic               is_right;
    logic [MOV_W-1:0]   move;
    logic [WIDTH-1:0]   window;
    stage_t             stage_d;
    stage_t             stage_q;

    assign op_e = shift_op_e'(op);

    fsh_fill #(.WIDTH(WIDTH)) u_fill (
        .op_i    (op_e),
        .src_i   (operand),
        .carry_i (carry_in),
        .word_o  (funnel_word),
        .right_o (is_right)
    );

    fsh_amount #(.WIDTH(WIDTH)) u_amount (
        .amt_i   (amount),
        .right_i (is_right),
        .pass_i  (op_e == OP_PASS),
        .move_o  (move)
    );

    fsh_window #(.WIDTH(WIDTH)) u_window (
        .word_i (funnel_word),
        .move_i (move),
        .win_o  (window)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        stage_d.data  = window;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.data;

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] operand,
    input logic [AMT_W-1:0] amount,
    input logic             carry_in,
    input logic [2:0]       op,
    input logic             out_valid,
    input logic [WIDTH-1:0] result
);
    logic prev_rst_q;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (prev_rst_q == 1'b1) begin
            p_reset_clear_r10: assert (result == '0 && out_valid == 1'b0)
                else $error("reset did not clear outputs");
        end
    end

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_pass_through_r8: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b111) |=> (result == $past(operand)));

    p_right_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ((op == 3'b001 || op == 3'b010 || op == 3'b100 || op == 3'b110) && amount == '0)
        |=> (result == $past(operand)));

    p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

    p_rot_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b011 || op == 3'b100) |=> ($countones(result) == $countones($past(operand))));

    p_sll_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000 && amount != '0) |=> (result[0] == 1'b0));

    p_rcl_low_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b101 && amount != '0) |=> (result[0] == $past(carry_in)));

    p_rcr_top_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b110 && amount != '0) |=> (result[WIDTH-1] == $past(carry_in)));

    p_srl_top_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b001 && amount != '0) |=> (result[WIDTH-1] == 1'b0));

endmodule

bind funnel_shifter funnel_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .amount    (amount),
    .carry_in  (carry_in),
    .op        (op),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/funnel_shifter_tb_top.sv
module funnel_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  amount = '0;
    logic        carry_in = 1'b0;
    logic [2:0]  op = 3'b111;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    funnel_shifter dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .operand   (operand),
        .amount    (amount),
        .carry_in  (carry_in),
        .op        (op),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                          input int n, input logic c);
        logic [31:0] ones;
        ones = 32'hFFFF_FFFF;
        case (o)
            3'b000: return a << n;
            3'b001: return a >> n;
            3'b010: return 32'($signed(a) >>> n);
            3'b011: return (a << n) | (a >> (32 - n));
            3'b100: return (a >> n) | (a << (32 - n));
            3'b101: return (a << n) | (c ? ~(ones << n) : 32'h0);
            3'b110: return (a >> n) | (c ? ~(ones >> n) : 32'h0);
            default: return a;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one operation, wait one edge, compare at the following falling edge
    task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] a,
                          input int n, input logic c);
        @(negedge clk);
        op = o; operand = a; amount = 5'(n); carry_in = c; in_valid = 1'b1;
        @(negedge clk);
        check(req, result, model(o, a, n, c));
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        op = 3'b111; operand = 32'hDEAD_BEEF; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R10 result", result, 32'h0);
        check("R10 valid", {31'h0, out_valid}, 32'h0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_sll;
        for (int n = 0; n < 32; n++) run_op("R1", 3'b000, 32'hA5C3_0F01, n, 1'b1);
        run_op("R1", 3'b000, 32'h0000_0001, 31, 1'b0);
    endtask

    task automatic t_srl;
        for (int n = 0; n < 32; n++) run_op("R2", 3'b001, 32'h8F00_F0A5, n, 1'b1);
    endtask

    task automatic t_sra;
        for (int n = 0; n < 32; n++) run_op("R3", 3'b010, 32'h9000_00F1, n, 1'b0);
        run_op("R3", 3'b010, 32'h7FFF_FFFF, 5, 1'b1);
    endtask

    task automatic t_rot;
        for (int n = 0; n < 32; n++) begin
            run_op("R4 rol", 3'b011, 32'h8000_0003, n, 1'b1);
            run_op("R4 ror", 3'b100, 32'hC000_0005, n, 1'b0);
        end
    endtask

    task automatic t_rcl;
        for (int n = 1; n < 32; n += 3) begin
            run_op("R5 c1", 3'b101, 32'h1234_5678, n, 1'b1);
            run_op("R5 c0", 3'b101, 32'hFFFF_FFFF, n, 1'b0);
        end
    endtask

    task automatic t_rcr;
        for (int n = 1; n < 32; n += 3) begin
            run_op("R6 c1", 3'b110, 32'h1234_5678, n, 1'b1);
            run_op("R6 c0", 3'b110, 32'hFFFF_FFFF, n, 1'b0);
        end
    endtask

    task automatic t_right_zero;
        run_op("R7 srl", 3'b001, 32'hCAFE_F00D, 0, 1'b1);
        run_op("R7 sra", 3'b010, 32'h8000_0001, 0, 1'b1);
        run_op("R7 ror", 3'b100, 32'h0F0F_1234, 0, 1'b0);
        run_op("R7 rcr", 3'b110, 32'h5555_AAAA, 0, 1'b1);
    endtask

    task automatic t_pass;
        for (int n = 0; n < 32; n += 7) run_op("R8", 3'b111, 32'h3C3C_0FF0 ^ 32'(n), n, n[0]);
    endtask

    task automatic t_valid;
        @(negedge clk);
        op = 3'b011; operand = 32'h0000_00FF; amount = 5'd8; in_valid = 1'b1;
        @(negedge clk);
        check("R9 valid high", {31'h0, out_valid}, 32'h1);
        check("R9 data", result, 32'h0000_FF00);
        op = 3'b000; operand = 32'h1; amount = 5'd4; in_valid = 1'b0;
        @(negedge clk);
        check("R9 valid low", {31'h0, out_valid}, 32'h0);
        check("R9 data next", result, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_sll();
        t_srl();
        t_sra();
        t_rot();
        t_rcl();
        t_rcr();
        t_right_zero();
        t_pass();
        t_valid();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule